// File: doc/BRIEF.md
# Byte-Wide Strobed Bus Target

This block is the target end of a byte-wide, strobe-clocked bus driven by a bit-banging host. The host frames each access with an active-low chip select. It first sends one address byte, marked by the address-latch line. It then moves two data bytes, most significant byte first, in the direction given by a mode line. The target samples all bus lines through synchronizers and counts strobe rising edges inside the chip-select frame. It turns each access into a single read request or write strobe on a simple internal register port.

The register side may take any number of cycles to answer. Once the host raises chip select after the data bytes, the target shows busy until the access has completed. On a read, the host then repeats the data-byte pair without a new address and receives the value again. On a write, the host pulses chip select and samples busy after each pulse.

Top module: `sbus_target`

## Requirements
- R1: While reset is held low, `bus_busy`, `bus_d_oe`, `reg_we` and `reg_rd_req` are all 0.
- R2: A strobe rising edge with chip select low and the address-latch line high stores the data lines as the register address on `reg_addr`. In read mode (mode line 0), `reg_rd_req` pulses for exactly one cycle afterwards, so one read request is made per address byte.
- R3: In write mode (mode line 1), the first data strobe after an address gives bits 15:8 and the second gives bits 7:0. After the second, `reg_we` pulses for exactly one cycle with `reg_wdata` = {first, second}.
- R4: In read mode, the target presents bits 15:8 of the served value on `bus_d_out` until the first data strobe, and bits 7:0 after it.
- R5: Strobe edges seen while chip select is high have no effect: no address capture, no request and no write.
- R6: With chip select high, `bus_busy` is 1 while the register side has not acknowledged the access, and 0 once it has. With chip select low, `bus_busy` is 0.
- R7: After a read reports busy, a new pair of data strobes without an address serves the value again from the high byte, with no new read request. The pair reports busy if the acknowledge arrived during or just before it.
- R8: After a write reports busy, each low-then-high pulse of chip select updates `bus_busy` to the current completion state.
- R9: `bus_d_oe` is 1 only while the mode line reads 0 and chip select reads low.
- R10: Data strobes after the second data byte of an access are ignored: no second write and no change to `reg_wdata`.

Ports are listed with the default parameter `DW` = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select from the host, active low |
| bus_stb | input | 1 | Byte strobe, acts on its rising edge |
| bus_ale | input | 1 | High marks the strobed byte as an address |
| bus_dir | input | 1 | Mode: 1 = host writes, 0 = host reads |
| bus_d_in | input | 8 | Data lines as driven by the host |
| bus_d_out | output | 8 | Data byte the target presents on a read |
| bus_d_oe | output | 1 | Output enable for the data lines |
| bus_busy | output | 1 | Ready/busy line, 1 = access still open |
| reg_addr | output | 8 | Register address of the current access |
| reg_wdata | output | 16 | Assembled write data |
| reg_we | output | 1 | One-cycle write strobe to the register side |
| reg_rd_req | output | 1 | One-cycle read request to the register side |
| reg_rdata | input | 16 | Read data from the register side, valid with `reg_ack` |
| reg_ack | input | 1 | One-cycle completion of the open request |

## Verification
The bench runs register-side latencies that are short, long and in between. A long latency forces busy on both reads and writes. A design that drops the read retry would hang, or would return the stale value from before the acknowledge. An intermediate latency lets the acknowledge land while a data pair is in flight. A target that ignored this would report ready with a torn high/low pair. Strobes sent with chip select high are checked against the address and write outputs, and would corrupt the address if the frame were not qualified. A third data strobe after a write is checked for a duplicate write strobe, which a byte counter that wraps instead of stopping would produce.

// File: rtl/sbt_pkg.sv
// Shared types for the strobed bus target.
package sbt_pkg;
    // Byte position inside one access frame.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no address seen yet
        PH_HI   = 2'd1,   // next data strobe carries bits 15:8
        PH_LO   = 2'd2,   // next data strobe carries bits 7:0
        PH_DONE = 2'd3    // both bytes moved, further strobes ignored
    } sbt_phase_e;
endpackage

// File: rtl/sbt_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is treated on its own; bits that belong together are only
// used after the host has held them stable for longer than the stage count.
module sbt_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the raw inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sbt_strobe_decode.sv
// Turns synchronized strobe, chip select and address-latch levels into
// single-cycle events. Assumes the inputs come from sbt_sync with equal delay,
// so the address-latch level is aligned with the strobe edge it qualifies.
module sbt_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_s,
    input  logic cs_n_s,
    input  logic ale_s,
    output logic addr_evt,
    output logic data_evt,
    output logic cs_rise
);
    logic stb_q;
    logic cs_n_q;
    logic stb_rise;

    // Remember the previous level of strobe and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            stb_q  <= stb_s;
            cs_n_q <= cs_n_s;
        end
    end

    // A strobe edge counts only inside a chip-select frame.
    assign stb_rise = stb_s & ~stb_q & ~cs_n_s;
    assign addr_evt = stb_rise & ale_s;
    assign data_evt = stb_rise & ~ale_s;
    assign cs_rise  = cs_n_s & ~cs_n_q;
endmodule

// File: rtl/sbt_engine.sv
// Access engine: stores the address, tracks the byte phase, assembles write
// data, issues register-side requests and tracks completion. The read value
// counts as fresh only if no request was open during the last HIST cycles
// before the first data strobe was seen. This covers the case where the host
// sampled the high byte before the synchronized edge arrived.
module sbt_engine
    import sbt_pkg::*;
#(
    parameter int  DW          = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int RW          = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_evt,
    input  logic          data_evt,
    input  logic          cs_rise,
    input  logic          dir_s,
    input  logic [DW-1:0] din,
    input  logic [RW-1:0] reg_rdata,
    input  logic          reg_ack,
    output logic [DW-1:0] addr,
    output logic [RW-1:0] wdata,
    output logic          we,
    output logic          rd_req,
    output logic [RW-1:0] rd_buf,
    output sbt_phase_e    phase,
    output logic          pending,
    output logic          fresh
);
    localparam int HIST = SYNC_STAGES + 3;

    logic            wr_mode;
    logic [DW-1:0]   hi_q;
    logic [HIST-1:0] pend_hist;

    // Record how long ago a request was last open.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_hist <= '0;
        else        pend_hist <= {pend_hist[HIST-2:0], pending};
    end

    // Phase tracking, byte capture, request pulses and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            addr    <= '0;
            hi_q    <= '0;
            wdata   <= '0;
            we      <= 1'b0;
            rd_req  <= 1'b0;
            pending <= 1'b0;
            fresh   <= 1'b1;
            wr_mode <= 1'b1;
            rd_buf  <= '0;
        end else begin
            we     <= 1'b0;
            rd_req <= 1'b0;
            if (reg_ack) begin
                pending <= 1'b0;
                if (!wr_mode) rd_buf <= reg_rdata;
            end
            if (addr_evt) begin
                addr    <= din;
                wr_mode <= dir_s;
                phase   <= PH_HI;
                fresh   <= dir_s;
                if (!dir_s) begin
                    rd_req  <= 1'b1;
                    pending <= 1'b1;
                end
            end else if (data_evt) begin
                case (phase)
                    PH_HI: begin
                        if (wr_mode) hi_q <= din;
                        else         fresh <= ~(pending | (|pend_hist));
                        phase <= PH_LO;
                    end
                    PH_LO: begin
                        if (wr_mode) begin
                            wdata   <= {hi_q, din};
                            we      <= 1'b1;
                            pending <= 1'b1;
                        end
                        phase <= PH_DONE;
                    end
                    default: ;
                endcase
            end else if (cs_rise && phase == PH_DONE && !wr_mode) begin
                phase <= PH_HI;
            end
        end
    end
endmodule

// File: rtl/sbus_target.sv
// Target side of a byte-wide strobed bus. All bus inputs are synchronized.
// Strobe edges inside a chip-select frame become address or data bytes, which
// drive a single-request register port. Assumes the host holds data and the
// address-latch line stable around each strobe, and keeps strobe low between
// bytes.
module sbus_target
    import sbt_pkg::*;
#(
    parameter int  DW          = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int RW          = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_stb,
    input  logic          bus_ale,
    input  logic          bus_dir,
    input  logic [DW-1:0] bus_d_in,
    output logic [DW-1:0] bus_d_out,
    output logic          bus_d_oe,
    output logic          bus_busy,
    output logic [DW-1:0] reg_addr,
    output logic [RW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_rd_req,
    input  logic [RW-1:0] reg_rdata,
    input  logic          reg_ack
);
    localparam int SW = DW + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b0, 1'b1, {DW{1'b0}}};

    logic [SW-1:0] raw_bus;
    logic [SW-1:0] sync_bus;
    logic          dir_s, ale_s, stb_s, cs_n_s;
    logic [DW-1:0] din_s;
    logic          addr_evt, data_evt, cs_rise;
    logic [RW-1:0] rd_buf;
    sbt_phase_e    phase;
    logic          pending, fresh;

    assign raw_bus = {bus_dir, bus_ale, bus_stb, bus_cs_n, bus_d_in};
    assign {dir_s, ale_s, stb_s, cs_n_s, din_s} = sync_bus;

    sbt_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    sbt_strobe_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_s    (stb_s),
        .cs_n_s   (cs_n_s),
        .ale_s    (ale_s),
        .addr_evt (addr_evt),
        .data_evt (data_evt),
        .cs_rise  (cs_rise)
    );

    sbt_engine #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_evt  (addr_evt),
        .data_evt  (data_evt),
        .cs_rise   (cs_rise),
        .dir_s     (dir_s),
        .din       (din_s),
        .reg_rdata (reg_rdata),
        .reg_ack   (reg_ack),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .rd_req    (reg_rd_req),
        .rd_buf    (rd_buf),
        .phase     (phase),
        .pending   (pending),
        .fresh     (fresh)
    );

    // Register the bus-facing outputs: busy, output enable and the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_busy  <= 1'b0;
            bus_d_oe  <= 1'b0;
            bus_d_out <= '0;
        end else begin
            bus_busy  <= cs_n_s & (pending | ~fresh);
            bus_d_oe  <= ~cs_n_s & ~dir_s;
            bus_d_out <= (phase == PH_HI) ? rd_buf[RW-1:DW] : rd_buf[DW-1:0];
        end
    end
endmodule

// File: rtl/sbt_checker.sv
// Protocol checks on the strobed bus target, attached by bind.
module sbt_checker
    import sbt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic       reg_rd_req,
    input logic       bus_busy,
    input logic       bus_d_oe,
    input logic       cs_n_s,
    input sbt_phase_e phase
);
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_we_closes_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> phase == PH_DONE);

    p_rdreq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> !reg_rd_req);

    p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_rd_req));

    p_busy_only_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> $past(cs_n_s));

    p_no_drive_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_busy && bus_d_oe));
endmodule

bind sbus_target sbt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_rd_req (reg_rd_req),
    .bus_busy   (bus_busy),
    .bus_d_oe   (bus_d_oe),
    .cs_n_s     (cs_n_s),
    .phase      (phase)
);

// File: tb/sbus_target_tb.sv
// Bench: plays the host of the strobed bus and a register bank with a
// per-access latency, walks a vector table, then runs directed corner cases.
module sbus_target_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_cs_n, bus_stb, bus_ale, bus_dir;
    logic [7:0]  bus_d_in, bus_d_out;
    logic        bus_d_oe, bus_busy;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_we, reg_rd_req, reg_ack;

    always #4 clk = ~clk;   // 125 MHz

    sbus_target u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_stb(bus_stb),
        .bus_ale(bus_ale), .bus_dir(bus_dir), .bus_d_in(bus_d_in),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_busy(bus_busy),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rd_req(reg_rd_req), .reg_rdata(reg_rdata), .reg_ack(reg_ack)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    function automatic logic [15:0] init_val(input logic [7:0] a);
        return {a, ~a} ^ 16'h5A00;
    endfunction

    // Register bank with programmable latency.
    logic [15:0] bank [256];
    logic [15:0] model [256];
    logic [7:0]  req_addr;
    int          cur_lat = 1;
    int          lat_cnt;
    int          we_cnt, rd_cnt;
    logic [15:0] cap_wdata;

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i]  = init_val(8'(i));
            model[i] = init_val(8'(i));
        end
    end

    // Serve register requests and count the one-cycle strobes.
    always @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt   <= 0;
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
            we_cnt    <= 0;
            rd_cnt    <= 0;
            req_addr  <= '0;
            cap_wdata <= '0;
        end else begin
            reg_ack <= 1'b0;
            if (reg_we) begin
                bank[reg_addr] <= reg_wdata;
                cap_wdata      <= reg_wdata;
                we_cnt         <= we_cnt + 1;
                lat_cnt        <= cur_lat;
            end else if (reg_rd_req) begin
                req_addr <= reg_addr;
                rd_cnt   <= rd_cnt + 1;
                lat_cnt  <= cur_lat;
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    reg_ack   <= 1'b1;
                    reg_rdata <= bank[req_addr];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One byte phase of the host: lines low, set up, raise strobe, sample.
    task automatic bus_byte(input logic is_adr, input logic [7:0] val,
                            output logic [7:0] seen);
        bus_cs_n = 1'b0; bus_stb = 1'b0; bus_ale = 1'b0;
        idle(6);
        bus_ale  = is_adr;
        bus_d_in = val;
        idle(1);
        bus_stb = 1'b1;
        idle(1);
        seen = bus_d_out;
        idle(5);
    endtask

    task automatic close_frame(output logic busy);
        bus_cs_n = 1'b1;
        idle(8);
        busy = bus_busy;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] v,
                            output int busy_seen);
        logic [7:0] dummy;
        logic       b;
        busy_seen = 0;
        bus_dir = 1'b1;
        idle(4);
        bus_byte(1'b1, a, dummy);
        chk(bus_d_oe == 1'b0, "R9 oe off in write", 32'(bus_d_oe), 0);
        bus_byte(1'b0, v[15:8], dummy);
        bus_byte(1'b0, v[7:0], dummy);
        close_frame(b);
        for (int t = 0; t < 40 && b; t++) begin
            busy_seen++;
            bus_cs_n = 1'b0;
            idle(3);
            bus_cs_n = 1'b1;
            idle(8);
            b = bus_busy;
        end
        chk(b == 1'b0, "R8 write busy clears", 32'(b), 0);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] v,
                           output int busy_seen);
        logic [7:0] hi, lo, dummy;
        logic       b;
        busy_seen = 0;
        bus_dir = 1'b0;
        idle(4);
        bus_byte(1'b1, a, dummy);
        chk(bus_d_oe == 1'b1, "R9 oe on in read", 32'(bus_d_oe), 1);
        b = 1'b1;
        for (int t = 0; t < 40 && b; t++) begin
            bus_byte(1'b0, 8'h00, hi);
            bus_byte(1'b0, 8'h00, lo);
            close_frame(b);
            if (b) busy_seen++;
        end
        chk(bus_d_oe == 1'b0, "R9 oe off with cs high", 32'(bus_d_oe), 0);
        chk(b == 1'b0, "R7 read retry ends ready", 32'(b), 0);
        v = {hi, lo};
    endtask

    // Vector: {write, addr, data, latency}
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 8'h10, 16'hBEEF, 8'd1},
        {1'b0, 8'h10, 16'h0000, 8'd1},
        {1'b0, 8'h22, 16'h0000, 8'd60},
        {1'b1, 8'h22, 16'h0F5A, 8'd60},
        {1'b0, 8'h22, 16'h0000, 8'd16},
        {1'b1, 8'hFF, 16'h8001, 8'd3},
        {1'b0, 8'hFF, 16'h0000, 8'd3},
        {1'b0, 8'h00, 16'h0000, 8'd60}
    };

    initial begin
        rst_n = 1'b0;
        bus_cs_n = 1'b1; bus_stb = 1'b0; bus_ale = 1'b0; bus_dir = 1'b1;
        bus_d_in = '0;
        idle(5);
        // R1: outputs quiet under reset
        chk(bus_busy == 0, "R1 busy in reset", 32'(bus_busy), 0);
        chk(bus_d_oe == 0, "R1 oe in reset", 32'(bus_d_oe), 0);
        chk(reg_we == 0 && reg_rd_req == 0, "R1 strobes in reset",
            32'({reg_we, reg_rd_req}), 0);
        rst_n = 1'b1;
        idle(5);

        for (int i = 0; i < 8; i++) begin
            logic        wr;
            logic [7:0]  a;
            logic [15:0] d, got;
            int          lat, bs, we0, rd0;
            {wr, a, d} = VEC[i][32:8];
            lat = int'(VEC[i][7:0]);
            cur_lat = lat;
            we0 = we_cnt; rd0 = rd_cnt;
            if (wr) begin
                do_write(a, d, bs);
                model[a] = d;
                chk(we_cnt - we0 == 1, "R3 one write strobe", 32'(we_cnt - we0), 1);
                chk(cap_wdata == d, "R3 write data hi-lo order", 32'(cap_wdata), 32'(d));
                chk(reg_addr == a, "R2 address captured", 32'(reg_addr), 32'(a));
                if (lat >= 40) chk(bs > 0, "R8 write busy reported", 32'(bs), 1);
                if (lat <= 4)  chk(bs == 0, "R6 short write not busy", 32'(bs), 0);
            end else begin
                do_read(a, got, bs);
                chk(got == model[a], "R4 read value hi then lo", 32'(got), 32'(model[a]));
                chk(rd_cnt - rd0 == 1, "R7 one request despite retries",
                    32'(rd_cnt - rd0), 1);
                chk(reg_addr == a, "R2 read address captured", 32'(reg_addr), 32'(a));
                if (lat >= 40) chk(bs > 0, "R6 read busy reported", 32'(bs), 1);
                if (lat <= 4)  chk(bs == 0, "R6 short read not busy", 32'(bs), 0);
            end
        end

        // R5: strobes with chip select high are ignored
        begin
            int we0, rd0;
            logic [7:0] a0;
            we0 = we_cnt; rd0 = rd_cnt; a0 = reg_addr;
            bus_dir = 1'b1; bus_cs_n = 1'b1;
            for (int k = 0; k < 3; k++) begin
                bus_stb = 1'b0; bus_ale = (k == 0); bus_d_in = 8'h33 + 8'(k);
                idle(6);
                bus_stb = 1'b1;
                idle(6);
            end
            bus_stb = 1'b0;
            idle(6);
            chk(reg_addr == a0, "R5 address kept with cs high", 32'(reg_addr), 32'(a0));
            chk(we_cnt == we0 && rd_cnt == rd0, "R5 no request with cs high",
                32'(we_cnt - we0 + rd_cnt - rd0), 0);
            chk(bus_busy == 0, "R6 idle not busy", 32'(bus_busy), 0);
        end

        // R10: a third data strobe after the low byte is ignored
        begin
            logic [7:0] dummy;
            logic       b;
            int we0;
            cur_lat = 2;
            bus_dir = 1'b1;
            idle(4);
            we0 = we_cnt;
            bus_byte(1'b1, 8'h40, dummy);
            bus_byte(1'b0, 8'h12, dummy);
            bus_byte(1'b0, 8'h34, dummy);
            bus_byte(1'b0, 8'hFF, dummy);
            close_frame(b);
            chk(we_cnt - we0 == 1, "R10 no extra write", 32'(we_cnt - we0), 1);
            chk(reg_wdata == 16'h1234, "R10 write data unchanged",
                32'(reg_wdata), 32'h1234);
            chk(b == 0, "R6 busy low after completion", 32'(b), 0);
        end

        // R9: chip select low in write mode keeps the lines undriven
        bus_cs_n = 1'b0; bus_stb = 1'b0; bus_dir = 1'b1;
        idle(6);
        chk(bus_d_oe == 0, "R9 oe off write mode cs low", 32'(bus_d_oe), 0);
        bus_cs_n = 1'b1;
        idle(6);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule